// File: doc/BRIEF.md
# IDE Adapter Local Register Decoder

This block sits between a host expansion bus and a multi-port IDE adapter. It turns byte accesses on the host bus into chip-selects for the IDE register sets and for a local expansion port. It answers reads of per-port interrupt-status bytes and maps a byte-wide ROM above the 4 KB local register window. All of its decoding is combinational. The only state it holds is a single flag, and that flag decides whether IDE interrupts reach the host.

The flag is set by a write of any value to the enable range. Nothing but reset clears it, and software cannot read it back. This keeps the host interrupt line quiet while drives power up, because some drives hold their interrupt output active during that time. The host interrupt request is the OR of the interrupt lines of the ports that are present, gated by the flag.

A parameter chooses the variant. The three-port variant has four IDE register-set selects. The two-port variant has two selects and ignores everything belonging to the third port.

Top module: `ide_card_decoder`

## Requirements
- R1: While a read or write strobe is active, address pages $A, $B, $C and $D (addr[11:8]) of the local window (addr[15:12]=0) assert `ide_cs[0]`, `ide_cs[1]`, `ide_cs[2]` and `ide_cs[3]` respectively. No more than one of the select outputs is ever active at a time.
- R2: While a strobe is active, page $E of the local window asserts `xport_cs`.
- R3: A read in $F00-$F3F, $F40-$F7F or $F80-$FBF returns the level of interrupt line 0, 1 or 2 in bit 7 of `rdata`. Bits 6 to 0 read as 0.
- R4: In the two-port variant, `ide_cs[3:2]` never assert, the $F80 status range reads 0, and interrupt line 2 never reaches `host_irq`.
- R5: A write of any data value to any address in $FC0-$FFF sets the pass-through flag on the next clock edge. A read of that range does not set it.
- R6: Once set, the flag stays set until reset. A read of $FC0-$FFF returns 0.
- R7: `host_irq` equals the pass-through flag ANDed with the OR of the present interrupt lines.
- R8: A read of an even address at or above $1000 asserts `rom_rd`, drives `rom_addr` with the same address and returns `rom_data`. A read of an odd address there returns 0 and leaves `rom_rd` low.
- R9: The range $000-$9FF asserts no select, reads return 0, and writes leave the flag unchanged.
- R10: A synchronous active-high reset clears the pass-through flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address within the card |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data (value irrelevant) |
| ide_irq | input | 3 | Raw IDE interrupt lines, one per port |
| rom_data | input | 8 | Byte from the ROM |
| ide_cs | output | 4 | IDE register-set selects |
| xport_cs | output | 1 | Local expansion-port select |
| rom_rd | output | 1 | ROM read enable |
| rom_addr | output | ADDR_W | ROM byte offset |
| rdata | output | 8 | Read data |
| host_irq | output | 1 | Host interrupt request |

## Verification
Range edges are probed just inside and just outside each page. This separates a correct page compare from an off-by-one or swapped decode. Interrupt patterns with a single line high, on mirror addresses near the start and end of each status range, show whether each status byte is tied to the right port and whether the mirroring works. Enable-range writes with different data values, placed after reads and reserved-range writes, show that the flag responds to any write in that range and to nothing else. The flag is then checked to hold after further accesses and to clear only on reset. A two-port instance, driven by the same stimulus, shows that every third-port path is suppressed.

// File: rtl/ide_card_decoder.sv
module ide_card_decoder #(
  parameter int ADDR_W     = 16,
  parameter bit THREE_PORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wdata,
  input  logic [2:0]        ide_irq,
  input  logic [7:0]        rom_data,
  output logic [3:0]        ide_cs,
  output logic              xport_cs,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [7:0]        rdata,
  output logic              host_irq
);

  localparam int       NSET     = THREE_PORT ? 4 : 2;
  localparam logic [2:0] IRQ_MASK = THREE_PORT ? 3'b111 : 3'b011;

  logic       access, local_win, stat_page;
  logic [3:0] page;
  logic [1:0] sub;
  logic [2:0] live_irq;
  logic       en_hit, pass_en_q;
  logic [7:0] unused_wdata;

  assign unused_wdata = wdata;
  assign access    = rd_stb | wr_stb;
  assign local_win = (addr[ADDR_W-1:12] == '0);
  assign page      = addr[11:8];
  assign sub       = addr[7:6];
  assign stat_page = local_win && (page == 4'hF);
  assign live_irq  = ide_irq & IRQ_MASK;

  for (genvar k = 0; k < 4; k++) begin : g_cs
    if (k < NSET) begin : g_on
      assign ide_cs[k] = access && local_win && (page == 4'(4'hA + k));
    end else begin : g_off
      assign ide_cs[k] = 1'b0;
    end
  end

  assign xport_cs = access && local_win && (page == 4'hE);
  assign rom_rd   = rd_stb && !local_win && !addr[0];
  assign rom_addr = addr;

  always_comb begin
    rdata = 8'h00;
    if (rd_stb) begin
      if (rom_rd)
        rdata = rom_data;
      else if (stat_page && sub != 2'd3)
        rdata = {live_irq[sub], 7'b0};
    end
  end

  assign en_hit = wr_stb && stat_page && (sub == 2'd3);

  always_ff @(posedge clk) begin
    if (rst)
      pass_en_q <= 1'b0;
    else if (en_hit)
      pass_en_q <= 1'b1;
  end

  assign host_irq = pass_en_q & (|live_irq);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ide_cs, xport_cs, rom_rd})); // R1
  AST_TWO_PORT_CS: assert property (@(posedge clk) disable iff (rst)
    (access && !THREE_PORT) |-> (ide_cs[3:2] == 2'b00)); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && addr[ADDR_W-1:6] == {{(ADDR_W-12){1'b0}}, 6'b111111}) |=> pass_en_q); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    pass_en_q |=> pass_en_q); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !pass_en_q |-> !host_irq); // R7
  AST_ROM_EVEN: assert property (@(posedge clk) disable iff (rst)
    rom_rd |-> (!addr[0] && rd_stb)); // R8

endmodule

// File: tb/ide_card_decoder_tb.sv
module ide_card_decoder_tb_top;
  logic        clk = 0;
  logic        rst;
  logic [15:0] addr;
  logic        rd_stb, wr_stb;
  logic [7:0]  wdata, rom_data;
  logic [2:0]  ide_irq;
  logic [3:0]  cs3, cs2;
  logic        xp3, xp2, rr3, rr2, hi3, hi2;
  logic [15:0] ra3, ra2;
  logic [7:0]  rd3, rd2;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  ide_card_decoder #(.ADDR_W(16), .THREE_PORT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .ide_irq(ide_irq), .rom_data(rom_data), .ide_cs(cs3),
    .xport_cs(xp3), .rom_rd(rr3), .rom_addr(ra3), .rdata(rd3), .host_irq(hi3));

  ide_card_decoder #(.ADDR_W(16), .THREE_PORT(1'b0)) dut_two_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .ide_irq(ide_irq), .rom_data(rom_data), .ide_cs(cs2),
    .xport_cs(xp2), .rom_rd(rr2), .rom_addr(ra2), .rdata(rd2), .host_irq(hi2));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rd_stb = 0; wr_stb = 0; addr = 16'h0000;
  endtask

  task automatic rd_at(logic [15:0] a);
    @(negedge clk);
    addr = a; rd_stb = 1; wr_stb = 0;
    #1;
  endtask

  task automatic wr_at(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = 1; rd_stb = 0;
    @(posedge clk); #1;
    wr_stb = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; rd_stb = 0; wr_stb = 0;
    @(posedge clk); #1; rst = 0;
  endtask

  task automatic t_reset();
    ide_irq = 3'b111;
    do_reset();
    check("R10 host_irq after reset", hi3, 0);
    check("R10 selects idle", {cs3, xp3, rr3}, 0);
  endtask

  task automatic t_sets();
    rd_at(16'h0A00); check("R1 $A00", {cs3, xp3}, 5'b00010);
    rd_at(16'h0AFF); check("R1 $AFF", {cs3, xp3}, 5'b00010);
    rd_at(16'h0B10); check("R1 $B10", {cs3, xp3}, 5'b00100);
    rd_at(16'h0C00); check("R1 $C00", {cs3, xp3}, 5'b01000);
    @(negedge clk); addr = 16'h0DFF; wr_stb = 1; #1;
    check("R1 $DFF write", {cs3, xp3}, 5'b10000);
    wr_stb = 0;
    idle(); #1;
    check("R1 no strobe", {cs3, xp3}, 0);
    rd_at(16'h1A00); check("R1 outside window", cs3, 0);
  endtask

  task automatic t_xport();
    rd_at(16'h0E00); check("R2 $E00", {cs3, xp3}, 5'b00001);
    rd_at(16'h0EFF); check("R2 $EFF", {cs3, xp3}, 5'b00001);
    rd_at(16'h0F00); check("R2 $F00 no select", {cs3, xp3}, 0);
  endtask

  task automatic t_status();
    ide_irq = 3'b001;
    rd_at(16'h0F00); check("R3 port0 $F00", rd3, 8'h80);
    rd_at(16'h0F3F); check("R3 port0 mirror $F3F", rd3, 8'h80);
    rd_at(16'h0F40); check("R3 port1 low", rd3, 8'h00);
    ide_irq = 3'b010; #1;
    check("R3 port1 high", rd3, 8'h80);
    rd_at(16'h0F00); check("R3 port0 low", rd3, 8'h00);
    ide_irq = 3'b100;
    rd_at(16'h0FBF); check("R3 port2 mirror $FBF", rd3, 8'h80);
    check("R4 two-port port2 status", rd2, 8'h00);
    rd_at(16'h0F7F); check("R3 port1 mirror low", rd3, 8'h00);
    idle();
  endtask

  task automatic t_two_port();
    rd_at(16'h0C00); check("R4 two-port $C00", cs2, 0);
    rd_at(16'h0D80); check("R4 two-port $D80", cs2, 0);
    rd_at(16'h0A00); check("R4 two-port $A00", cs2, 4'b0001);
    idle();
  endtask

  task automatic t_reserved_and_reads();
    ide_irq = 3'b111;
    rd_at(16'h0000); check("R9 $000 read", {rd3, cs3, xp3, rr3}, 0);
    rd_at(16'h09FF); check("R9 $9FF read", {rd3, cs3, xp3, rr3}, 0);
    wr_at(16'h0500, 8'hFF);
    wr_at(16'h09FF, 8'h01);
    check("R9 reserved write no flag", hi3, 0);
    rd_at(16'h0FC0); @(posedge clk); #1;
    check("R5 read of $FC0 no flag", hi3, 0);
    check("R6 $FC0 reads 0", rd3, 0);
    idle();
  endtask

  task automatic t_flag();
    ide_irq = 3'b000;
    wr_at(16'h0FE7, 8'h00);
    check("R7 flag set, no irq", hi3, 0);
    ide_irq = 3'b001; #1;
    check("R5 flag set by any value", hi3, 1);
    ide_irq = 3'b010; #1; check("R7 port1 irq", hi3, 1);
    ide_irq = 3'b100; #1; check("R7 port2 irq", hi3, 1);
    check("R4 two-port ignores line 2", hi2, 0);
    ide_irq = 3'b001; #1; check("R7 two-port port0", hi2, 1);
    wr_at(16'h0500, 8'h00);
    rd_at(16'h0FFF); @(posedge clk); #1;
    check("R6 flag sticky", hi3, 1);
    check("R6 $FFF reads 0", rd3, 0);
    idle();
    do_reset();
    check("R10 flag cleared", hi3, 0);
  endtask

  task automatic t_rom();
    rom_data = 8'h5A;
    rd_at(16'h1000); check("R8 $1000 rom_rd", rr3, 1);
    check("R8 $1000 data", rd3, 8'h5A);
    check("R8 $1000 addr", ra3, 16'h1000);
    rd_at(16'hFFFE); check("R8 $FFFE addr", ra3, 16'hFFFE);
    check("R8 $FFFE data", rd3, 8'h5A);
    rd_at(16'h2001); check("R8 odd addr", {rr3, rd3}, 0);
    rd_at(16'h0FFE); check("R8 below $1000", rr3, 0);
    idle();
  endtask

  initial begin
    rst = 1; addr = 0; rd_stb = 0; wr_stb = 0; wdata = 0; ide_irq = 0; rom_data = 0;
    t_reset();
    t_sets();
    t_xport();
    t_status();
    t_two_port();
    t_reserved_and_reads();
    t_flag();
    t_rom();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule